// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port that sits on a simple APB-style register bus with 32-bit data. Software sets the level of each output pin and chooses whether each pin is an input or an output. It can also read back the pad levels after they pass through a two-flop synchronizer.

Every pin can raise an interrupt. A pin can trigger on a low level, a high level, a rising edge or a falling edge, and a separate per-pin override makes it trigger on both edges. Detected events are latched in a sticky status register, which software clears by writing ones to it. A mask register decides which latched events reach the two request lines. One line covers the lower sixteen pins and the other covers the upper sixteen.

Bus accesses take one cycle and have no wait states. A write takes effect at the clock edge on which select, enable and write are all high. Read data is driven combinationally during the access.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are zero and both request lines are low. A read of any address not listed in these requirements returns zero, including addresses from 0x20 upward.
- R2: A write to offset 0x00 sets `pad_out`, and a write to offset 0x04 sets `pad_oe`, where a 1 makes that pin an output. Both registers read back what was written.
- R3: Offset 0x08 returns `pad_in` after a two-flop synchronizer. Writes to 0x08 change no register.
- R4: Each pin has a 2-bit trigger code. For pin n below 16 the code is at offset 0x0C, bits 2*n+1:2*n. For pin n of 16 or above it is at offset 0x10, bits 2*(n-16)+1:2*(n-16).
- R5: Code 00 selects low-level trigger and code 01 selects high-level trigger. A level trigger sets the pin's status bit on every cycle the level holds, so a clear issued while the level persists leaves the bit set.
- R6: Code 10 sets the status bit on a synchronized rising transition, and code 11 sets it on a falling transition. The opposite transition sets nothing.
- R7: When a pin's bit at offset 0x1C is 1, both transitions set its status bit and its 2-bit code has no effect.
- R8: The status register is at offset 0x18. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a hardware event and a clear fall on the same cycle, the event wins.
- R9: The mask register is at offset 0x14, where a 1 enables the pin. `irq_lo` is the OR over pins 0 to 15 of status AND mask, and `irq_hi` is the same OR over pins 16 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pad_in | input | 32 | Pad levels |
| pad_out | output | 32 | Output data to pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Request for pins 0 to 15 |
| irq_hi | output | 1 | Request for pins 16 to 31 |

## Verification
The bench builds the block with the default `ADDR_W` of 6. That leaves the words from 0x20 to 0x3C unmapped, so the bench can check that reads there return zero. With 32 pins fixed by the register layout, the bench reaches pins in both halves, so it covers code placement in both trigger-config registers and both request lines. It also covers each trigger mode, the both-edge override and a clear that collides with a persisting level.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);

  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_PAD  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_CFGL = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_CFGH = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_DUAL = ADDR_W'('h1C);

  logic [31:0] out_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, flag_q, dual_q;
  logic [31:0] s1_q, s2_q, prev_q;
  logic [31:0] hit, clr, pend;
  logic        wr;

  assign wr      = psel & penable & pwrite;
  assign clr     = (wr && paddr == A_FLAG) ? pwdata : 32'h0;
  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign pend    = flag_q & mask_q;
  assign irq_lo  = |pend[15:0];
  assign irq_hi  = |pend[31:16];

  for (genvar g = 0; g < 32; g++) begin : g_pin
    logic [1:0] code;
    if (g < 16) begin : g_lo
      assign code = cfg_lo_q[2*g +: 2];
    end else begin : g_hi
      assign code = cfg_hi_q[2*(g-16) +: 2];
    end
    always_comb begin
      if (dual_q[g]) hit[g] = s2_q[g] ^ prev_q[g];
      else begin
        case (code)
          2'b00:   hit[g] = ~s2_q[g];
          2'b01:   hit[g] = s2_q[g];
          2'b10:   hit[g] = s2_q[g] & ~prev_q[g];
          default: hit[g] = ~s2_q[g] & prev_q[g];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      flag_q <= (flag_q & ~clr) | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      dual_q   <= '0;
    end else if (wr) begin
      case (paddr)
        A_OUT:   out_q    <= pwdata;
        A_DIR:   dir_q    <= pwdata;
        A_CFGL:  cfg_lo_q <= pwdata;
        A_CFGH:  cfg_hi_q <= pwdata;
        A_MASK:  mask_q   <= pwdata;
        A_DUAL:  dual_q   <= pwdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (paddr)
      A_OUT:   prdata = out_q;
      A_DIR:   prdata = dir_q;
      A_PAD:   prdata = s2_q;
      A_CFGL:  prdata = cfg_lo_q;
      A_CFGH:  prdata = cfg_hi_q;
      A_MASK:  prdata = mask_q;
      A_FLAG:  prdata = flag_q;
      A_DUAL:  prdata = dual_q;
      default: prdata = 32'h0;
    endcase
  end

  // R3
  pad_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == A_PAD) |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q)
                                && $stable(cfg_lo_q) && $stable(cfg_hi_q) && $stable(dual_q)));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == A_FLAG && (pwdata & hit) == 32'h0) |=> ((flag_q & $past(pwdata)) == 32'h0));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && paddr == A_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R7
  dual_edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dual_q & (s2_q ^ prev_q)) != 32'h0) |=>
      ((flag_q & $past(dual_q & (s2_q ^ prev_q))) == $past(dual_q & (s2_q ^ prev_q))));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 32'h0) |-> (!irq_lo && !irq_hi));

endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  localparam int AW = 6;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic [31:0]   pad_in = '0;
  logic [31:0]   pad_out, pad_oe;
  logic          irq_lo, irq_hi;
  int            checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi));

  localparam logic [69:0] VEC [9] = '{
    {6'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {6'h04, 32'h0000_FFFF, 32'h0000_FFFF},
    {6'h0C, 32'h1234_5678, 32'h1234_5678},
    {6'h10, 32'h8765_4321, 32'h8765_4321},
    {6'h14, 32'hFFFF_0000, 32'hFFFF_0000},
    {6'h1C, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
    {6'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h24, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h3C, 32'hDEAD_BEEF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    // R1: reset contents read while reset is held
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a*4), v);
      chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 reset oe", pad_oe, 32'h0);
    chk("R1 reset out", pad_out, 32'h0);
    chk("R1 reset irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    @(negedge clk); rst_n = 1;

    // R2 R4 R3 R1: table of write then readback vectors
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], v);
      chk("R2/R3/R4 table readback", v, VEC[i][31:0]);
    end

    // R2: port outputs follow registers
    wr(6'h00, 32'h1234_5678);
    wr(6'h04, 32'hFFFF_0000);
    chk("R2 pad_out", pad_out, 32'h1234_5678);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);

    // clean slate: all pins rising, unmasked, no dual
    wr(6'h00, 0); wr(6'h04, 0); wr(6'h14, 0); wr(6'h1C, 0);
    wr(6'h0C, 32'hAAAA_AAAA); wr(6'h10, 32'hAAAA_AAAA);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R8 clear all", v, 32'h0);

    // R6: rising on pin 3
    pad_in[3] = 1; settle();
    rd(6'h18, v); chk("R6 rising pin3", v, 32'h0000_0008);
    chk("R9 masked no irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    wr(6'h14, 32'h0000_0008);
    chk("R9 irq_lo on", {30'h0, irq_hi, irq_lo}, 32'h1);
    pad_in[3] = 0; settle();
    rd(6'h18, v); chk("R6 falling ignored on rising code", v, 32'h0000_0008);
    wr(6'h18, 32'h0000_0008);
    rd(6'h18, v); chk("R8 w1c pin3", v, 32'h0);
    chk("R9 irq_lo off", {30'h0, irq_hi, irq_lo}, 32'h0);

    // R4 R6: falling on pin 20 via upper config, bits 9:8
    wr(6'h10, 32'hAAAA_ABAA);
    pad_in[20] = 1; settle();
    rd(6'h18, v); chk("R6 rise ignored on falling code", v, 32'h0);
    pad_in[20] = 0; settle();
    rd(6'h18, v); chk("R4/R6 falling pin20", v, 32'h0010_0000);
    wr(6'h14, 32'h0010_0008);
    chk("R9 irq_hi only", {30'h0, irq_hi, irq_lo}, 32'h2);
    wr(6'h18, 32'h0010_0000);

    // R5: high level pin 5 (lower config bits 11:10)
    wr(6'h0C, 32'hAAAA_A6AA);
    rd(6'h18, v); chk("R5 high level idle", v, 32'h0);
    pad_in[5] = 1; settle();
    rd(6'h18, v); chk("R5 high level set", v, 32'h0000_0020);
    wr(6'h18, 32'h0000_0020);
    rd(6'h18, v); chk("R5/R8 set wins while level holds", v, 32'h0000_0020);
    pad_in[5] = 0; settle();
    wr(6'h18, 32'h0000_0020);
    rd(6'h18, v); chk("R5 cleared after level drops", v, 32'h0);

    // R5: low level pin 0 (bits 1:0 = 00)
    wr(6'h0C, 32'hAAAA_A6A8); settle();
    rd(6'h18, v); chk("R5 low level set", v, 32'h0000_0001);
    pad_in[0] = 1; settle();
    wr(6'h18, 32'h0000_0001);
    rd(6'h18, v); chk("R5 low level cleared", v, 32'h0);

    // R7: both edges on pin 7, rising code ignored
    wr(6'h1C, 32'h0000_0080);
    pad_in[7] = 1; settle();
    rd(6'h18, v); chk("R7 dual rise", v, 32'h0000_0080);
    wr(6'h18, 32'h0000_0080);
    pad_in[7] = 0; settle();
    rd(6'h18, v); chk("R7 dual fall", v, 32'h0000_0080);
    wr(6'h18, 32'h0);
    rd(6'h18, v); chk("R8 write zero keeps", v, 32'h0000_0080);
    wr(6'h18, 32'h0000_0080);

    // R3: pad status readback and ignored write
    wr(6'h00, 32'h0BAD_F00D);
    pad_in = 32'h5A5A_0081; settle();
    rd(6'h08, v); chk("R3 pad status", v, 32'h5A5A_0081);
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, v); chk("R3 pad after write", v, 32'h5A5A_0081);
    rd(6'h00, v); chk("R3 write to pad ignored", v, 32'h0BAD_F00D);
    rd(6'h14, v); chk("R3 mask untouched", v, 32'h0010_0008);

    finish_run();
  end
endmodule